// File: doc/BRIEF.md
# Multi-Mode Integer Multiplier

This block is the multiply unit of a 16-bit processor's execute stage. It is purely combinational. A mode code picks one of five multiply forms:

- a full 16×16 register product that keeps only the low half;
- unsigned and signed multiplies of the low bytes of two registers;
- a register low byte times a 6-bit immediate;
- one 6-bit immediate times another.

The block produces a 16-bit result and the negative, zero and overflow flag values. It also produces a write-enable that tells the flag register whether the operation updates flags.

Internally, a shared unsigned shift-add array works on operand magnitudes. The operand selector decides the magnitudes and the sign of the result. The flag stage then applies the sign to the product and derives the flags from the exact product. Division, register storage and pipelining stay outside the block.

Top module: `mmul_top`

## Requirements
- R1: Mode 0 (full) drives `product` with the low 16 bits of the unsigned 32-bit product `src_a × src_b`.
- R2: In mode 0, `flag_we` is 0 and `flag_n`, `flag_z` and `flag_v` are all 0.
- R3: Mode 1 (unsigned byte) multiplies `src_a[7:0]` by `src_b[7:0]` as unsigned values and drives `flag_we` = 1.
- R4: Mode 2 (signed byte) multiplies `src_a[7:0]` by `src_b[7:0]` as signed 8-bit values, gives the product sign-extended to 16 bits, and drives `flag_we` = 1. For example, 0x80 × 0x80 gives 0x4000, and 0xFF × 0x01 gives 0xFFFF with `flag_n` = 1.
- R5: Mode 3 (byte by immediate) multiplies `src_a[7:0]` by `imm_b` zero-extended, and drives `flag_we` = 1.
- R6: Mode 4 (double immediate) multiplies `imm_a` by `imm_b`, both zero-extended. It drives `flag_we` = 1, and `flag_v` is always 0 in this mode.
- R7: Whenever `flag_we` = 1, `flag_n` equals `product[15]`, and `flag_z` is 1 exactly when `product` is 0.
- R8: Whenever `flag_we` = 1, `flag_v` is 1 exactly when the exact product lies outside −32768..32767. For example, 255×255 sets it and 151×217 = 32767 does not.
- R9: Bits outside the operands a mode uses have no effect on any output:
  - `src_a[15:8]` and `src_b[15:8]` in modes 1 and 2;
  - `src_b` in mode 3;
  - `src_a` and `src_b` in mode 4.
- R10: Mode codes 5, 6 and 7 drive `product` = 0 and `flag_we`, `flag_n`, `flag_z`, `flag_v` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode | input | 3 | Multiply mode code (0..4 valid) |
| src_a | input | 16 | First register operand |
| src_b | input | 16 | Second register operand |
| imm_a | input | 6 | First immediate field |
| imm_b | input | 6 | Second immediate field |
| product | output | 16 | Result written to the destination register |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_v | output | 1 | Overflow flag value |
| flag_we | output | 1 | Flag register update enable |

## Verification
The overflow boundary is the hardest condition to reach from the ports. Only the unsigned byte mode can exceed the signed 16-bit range. The signed byte products stop at 16384, and both immediate forms stay below 16066. The stimulus therefore aims directed unsigned byte operands at the edge: 151×217 lands exactly on 32767, and 129×255 lands just over it. These are followed by sign-corner signed byte pairs and by randomized operands whose unused upper bits are filled with noise.

// File: rtl/mmul_pkg.sv
package mmul_pkg;

  typedef enum logic [2:0] {
    MM_FULL  = 3'd0,
    MM_UBYTE = 3'd1,
    MM_SBYTE = 3'd2,
    MM_BIMM  = 3'd3,
    MM_IMM2  = 3'd4
  } mm_mode_e;

  function automatic logic mode_valid(input logic [2:0] m);
    return (m <= 3'd4);
  endfunction

endpackage

// File: rtl/mmul_opsel.sv
module mmul_opsel
  import mmul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 6
) (
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_a,
  input  logic [IMM_W-1:0]  imm_b,
  output logic [DATA_W-1:0] mag_a,
  output logic [DATA_W-1:0] mag_b,
  output logic              neg,
  output logic              flag_we,
  output logic              valid
);

  localparam int BPAD = DATA_W - BYTE_W;
  localparam int IPAD = DATA_W - IMM_W;

  logic [BYTE_W-1:0] byte_a, byte_b;
  logic [BYTE_W-1:0] abs_a, abs_b;
  logic              sgn_a, sgn_b;

  // magnitude of the signed low bytes (0x80 maps to 0x80 = 128)
  always_comb begin
    byte_a = src_a[BYTE_W-1:0];
    byte_b = src_b[BYTE_W-1:0];
    sgn_a  = byte_a[BYTE_W-1];
    sgn_b  = byte_b[BYTE_W-1];
    abs_a  = sgn_a ? (~byte_a + 1'b1) : byte_a;
    abs_b  = sgn_b ? (~byte_b + 1'b1) : byte_b;
  end

  always_comb begin
    mag_a   = '0;
    mag_b   = '0;
    neg     = 1'b0;
    flag_we = 1'b0;
    valid   = mode_valid(mode);
    case (mode)
      MM_FULL: begin
        mag_a = src_a;
        mag_b = src_b;
      end
      MM_UBYTE: begin
        mag_a   = {{BPAD{1'b0}}, byte_a};
        mag_b   = {{BPAD{1'b0}}, byte_b};
        flag_we = 1'b1;
      end
      MM_SBYTE: begin
        mag_a   = {{BPAD{1'b0}}, abs_a};
        mag_b   = {{BPAD{1'b0}}, abs_b};
        neg     = sgn_a ^ sgn_b;
        flag_we = 1'b1;
      end
      MM_BIMM: begin
        mag_a   = {{BPAD{1'b0}}, byte_a};
        mag_b   = {{IPAD{1'b0}}, imm_b};
        flag_we = 1'b1;
      end
      MM_IMM2: begin
        mag_a   = {{IPAD{1'b0}}, imm_a};
        mag_b   = {{IPAD{1'b0}}, imm_b};
        flag_we = 1'b1;
      end
      default: begin
        mag_a   = '0;
        mag_b   = '0;
      end
    endcase
  end

endmodule

// File: rtl/mmul_core.sv
module mmul_core #(
  parameter int W = 16
) (
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod
);

  localparam int PW = 2 * W;

  logic [PW-1:0] acc [0:W];
  logic [PW-1:0] ext_a;

  assign ext_a  = {{W{1'b0}}, op_a};
  assign acc[0] = '0;

  // shift-add array: one partial product row per multiplier bit
  for (genvar i = 0; i < W; i++) begin : g_row
    logic [PW-1:0] pp;
    assign pp       = op_b[i] ? (ext_a << i) : '0;
    assign acc[i+1] = acc[i] + pp;
  end

  assign prod = acc[W];

endmodule

// File: rtl/mmul_flags.sv
module mmul_flags #(
  parameter int DATA_W = 16
) (
  input  logic [2*DATA_W-1:0] mag_prod,
  input  logic                neg,
  input  logic                valid,
  input  logic                flag_we,
  output logic [DATA_W-1:0]   product,
  output logic                flag_n,
  output logic                flag_z,
  output logic                flag_v
);

  localparam int PROD_W = 2 * DATA_W;
  localparam logic [PROD_W-1:0] POS_LIM = PROD_W'((64'd1 << (DATA_W-1)) - 64'd1);
  localparam logic [PROD_W-1:0] NEG_LIM = PROD_W'(64'd1 << (DATA_W-1));

  logic [DATA_W-1:0] low_mag;
  logic [DATA_W-1:0] low_res;
  logic              out_of_range;

  always_comb begin
    low_mag      = mag_prod[DATA_W-1:0];
    low_res      = neg ? (~low_mag + 1'b1) : low_mag;
    out_of_range = neg ? (mag_prod > NEG_LIM) : (mag_prod > POS_LIM);
    product      = valid ? low_res : '0;
    flag_n       = flag_we & low_res[DATA_W-1];
    flag_z       = flag_we & (low_res == '0);
    flag_v       = flag_we & out_of_range;
  end

endmodule

// File: rtl/mmul_top.sv
module mmul_top
  import mmul_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 6
) (
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_a,
  input  logic [IMM_W-1:0]  imm_b,
  output logic [DATA_W-1:0] product,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_we
);

  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] mag_a, mag_b;
  logic [PROD_W-1:0] mag_prod;
  logic              neg, valid;

  mmul_opsel #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W),
    .IMM_W (IMM_W)
  ) u_opsel (
    .mode   (mode),
    .src_a  (src_a),
    .src_b  (src_b),
    .imm_a  (imm_a),
    .imm_b  (imm_b),
    .mag_a  (mag_a),
    .mag_b  (mag_b),
    .neg    (neg),
    .flag_we(flag_we),
    .valid  (valid)
  );

  mmul_core #(
    .W(DATA_W)
  ) u_core (
    .op_a(mag_a),
    .op_b(mag_b),
    .prod(mag_prod)
  );

  mmul_flags #(
    .DATA_W(DATA_W)
  ) u_flags (
    .mag_prod(mag_prod),
    .neg     (neg),
    .valid   (valid),
    .flag_we (flag_we),
    .product (product),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_v  (flag_v)
  );

  // cross-module checks between the decoder and the flag stage
  always_comb begin
    if (!$isunknown({mode, product, flag_n, flag_z, flag_v, flag_we})) begin
      if (mode == MM_FULL)
        a_r2_full_no_flags: assert (!flag_we && !flag_n && !flag_z && !flag_v);
      if (flag_we)
        a_r7_zero_flag: assert (flag_z == (product == '0));
      if (flag_we)
        a_r7_neg_flag: assert (flag_n == product[DATA_W-1]);
      if (mode == MM_IMM2)
        a_r6_no_overflow: assert (!flag_v);
      if (mode > 3'd4)
        a_r10_idle_output: assert (product == '0 && !flag_we && !flag_v);
      if (mode == MM_SBYTE && product[DATA_W-1] == 1'b0 && flag_we)
        a_r4_no_ovf_signed: assert (!flag_v);
    end
  end

endmodule

// File: tb/mmul_top_bench.sv
module mmul_top_bench;

  typedef struct {
    logic [15:0] prod;
    logic        n, z, v, we;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [2:0]  mode;
  logic [15:0] src_a, src_b;
  logic [5:0]  imm_a, imm_b;
  logic [15:0] product;
  logic        flag_n, flag_z, flag_v, flag_we;

  int   checks   = 0;
  int   failures = 0;
  bit   done     = 0;
  exp_t q[$];

  mmul_top u_mmul_top (
    .mode   (mode),
    .src_a  (src_a),
    .src_b  (src_b),
    .imm_a  (imm_a),
    .imm_b  (imm_b),
    .product(product),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_v (flag_v),
    .flag_we(flag_we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic exp_t model(input logic [2:0] m, input logic [15:0] a,
                                 input logic [15:0] b, input logic [5:0] ia,
                                 input logic [5:0] ib, input string tag);
    exp_t   e;
    longint x;
    x    = 0;
    e.we = 1'b1;
    case (m)
      3'd0: begin x = longint'(a) * longint'(b); e.we = 1'b0; end
      3'd1: x = longint'(a[7:0]) * longint'(b[7:0]);
      3'd2: x = longint'($signed(a[7:0])) * longint'($signed(b[7:0]));
      3'd3: x = longint'(a[7:0]) * longint'(ib);
      3'd4: x = longint'(ia) * longint'(ib);
      default: begin x = 0; e.we = 1'b0; end
    endcase
    e.prod = x[15:0];
    e.n    = e.we && e.prod[15];
    e.z    = e.we && (e.prod == 16'd0);
    e.v    = e.we && (x > 32767 || x < -32768);
    e.tag  = tag;
    return e;
  endfunction

  task automatic drive(input logic [2:0] m, input logic [15:0] a, input logic [15:0] b,
                       input logic [5:0] ia, input logic [5:0] ib, input string tag);
    @(negedge clk);
    mode  = m;
    src_a = a;
    src_b = b;
    imm_a = ia;
    imm_b = ib;
    q.push_back(model(m, a, b, ia, ib, tag));
  endtask

  // monitor: compares settled outputs at the edge after each drive
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (product !== e.prod || flag_n !== e.n || flag_z !== e.z ||
          flag_v !== e.v || flag_we !== e.we) begin
        failures++;
        $display("FAIL %s: got p=%h n=%b z=%b v=%b we=%b exp p=%h n=%b z=%b v=%b we=%b",
                 e.tag, product, flag_n, flag_z, flag_v, flag_we,
                 e.prod, e.n, e.z, e.v, e.we);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode = 3'd0; src_a = '0; src_b = '0; imm_a = '0; imm_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state after reset: zero operands, full mode
    drive(3'd0, 16'h0000, 16'h0000, 6'd0, 6'd0, "R2 reset idle");
    // R1 full product truncation
    drive(3'd0, 16'hFFFF, 16'hFFFF, 6'd0, 6'd0, "R1 full max");
    drive(3'd0, 16'h1234, 16'h0100, 6'd5, 6'd9, "R1 full shift");
    drive(3'd0, 16'h8000, 16'h0002, 6'd0, 6'd0, "R2 full zero no flags");
    // R3 unsigned byte
    drive(3'd1, 16'h00FF, 16'h00FF, 6'd0, 6'd0, "R3 R8 ubyte 255x255 ovf");
    drive(3'd1, 16'h0097, 16'h00D9, 6'd0, 6'd0, "R8 ubyte 151x217 edge");
    drive(3'd1, 16'h0081, 16'h00FF, 6'd0, 6'd0, "R8 ubyte 129x255 over");
    drive(3'd1, 16'h0000, 16'h0037, 6'd0, 6'd0, "R7 ubyte zero");
    // R4 signed byte corners
    drive(3'd2, 16'h0080, 16'h0080, 6'd0, 6'd0, "R4 sbyte -128x-128");
    drive(3'd2, 16'h00FF, 16'h0001, 6'd0, 6'd0, "R4 sbyte -1x1");
    drive(3'd2, 16'h0080, 16'h007F, 6'd0, 6'd0, "R4 sbyte -128x127");
    drive(3'd2, 16'h00FE, 16'h0000, 6'd0, 6'd0, "R4 sbyte zero");
    // R5 byte by immediate
    drive(3'd3, 16'h00FF, 16'h5555, 6'd7, 6'd63, "R5 bimm 255x63");
    drive(3'd3, 16'h0010, 16'h0000, 6'd0, 6'd0, "R5 bimm zero imm");
    // R6 double immediate
    drive(3'd4, 16'hFFFF, 16'hFFFF, 6'd63, 6'd63, "R6 imm2 63x63");
    drive(3'd4, 16'h0000, 16'h0000, 6'd0, 6'd12, "R6 imm2 zero");
    // R9 ignored upper bits
    drive(3'd1, 16'hAB03, 16'hCD05, 6'd0, 6'd0, "R9 ubyte upper ignored");
    drive(3'd2, 16'h7FFF, 16'h8001, 6'd0, 6'd0, "R9 sbyte upper ignored");
    drive(3'd3, 16'hFF02, 16'hFFFF, 6'd0, 6'd3, "R9 bimm srcb ignored");
    drive(3'd4, 16'hFFFF, 16'h1234, 6'd2, 6'd3, "R9 imm2 regs ignored");
    // R10 invalid codes
    drive(3'd5, 16'h00FF, 16'h00FF, 6'd63, 6'd63, "R10 code5");
    drive(3'd6, 16'h1234, 16'h4321, 6'd1, 6'd1, "R10 code6");
    drive(3'd7, 16'hFFFF, 16'hFFFF, 6'd63, 6'd63, "R10 code7");
    // randomized sweep over all codes with noisy upper bits
    for (int i = 0; i < 400; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      drive(m, 16'($urandom), 16'($urandom), 6'($urandom), 6'($urandom), "R7 R8 random");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule